// File: doc/BRIEF.md
# Second-Order Delta-Sigma Modulator

This block is a purely digital second-order delta-sigma modulator. It takes a signed parallel sample and produces a single-bit stream. The proportion of ones in that stream follows the sample value. Two integrators sit in cascade ahead of a one-bit quantizer. The quantizer's previous decision comes back as a plus or minus full-scale value and is subtracted at both integrator inputs. The second integrator receives it at double weight, which shapes the quantization error as (1 - z^-1)^2.

The loop advances only on cycles where the sample strobe is high. On each such cycle it emits one new output bit. The block is meant to run heavily oversampled against the band of interest: for example, a stream of several kilohertz carrying a band of a few hertz. A decimating low-pass filter downstream recovers a parallel word from the ones density. Both integrators saturate at the limits of their width, so an overdriven input cannot fold the loop state over.

Top module: `dsm2_modulator`

## Requirements
- R1: A synchronous reset forces the output bit to 0 and clears both integrators to zero. Reset takes priority over the sample strobe, and the first sample after reset therefore starts from an all-zero state.
- R2: On a cycle with the sample strobe low, the output bit and both integrators keep their values, whatever the sample input holds. The bit sequence that follows is the one the enabled samples alone would give.
- R3: On each enabled cycle, the output bit becomes 1 if the freshly updated second integrator is greater than or equal to zero, and 0 if it is negative.
- R4: On each enabled cycle, the first integrator adds the input minus the feedback value. The feedback value is +FULL_SCALE when the current output bit is 1 and -FULL_SCALE when it is 0.
- R5: On each enabled cycle, the second integrator adds the pre-update first integrator minus twice the feedback value from R4.
- R6: Each integrator is IN_W+GUARD bits wide in two's complement, with GUARD at least 4. A result above the largest value is held at that largest value, and a result below the smallest value is held at the smallest value; it never wraps.
- R7: For a constant input x with |x| at most about two thirds of FULL_SCALE, the fraction of ones over a long run is (x + FULL_SCALE) / (2 * FULL_SCALE). This holds within a few counts per hundred samples.
- R8: The sample input is an IN_W-bit two's-complement word. Codes beyond plus or minus FULL_SCALE are accepted as overrange and handled through R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_en_i | input | 1 | Sample strobe; the loop advances only when high |
| smp_i | input | IN_W | Signed input sample, two's complement |
| bit_o | output | 1 | Modulator output bit, registered |

## Verification
The bench builds the block with IN_W=8, GUARD=4 and FULL_SCALE=64. At these values the integrators span only plus or minus 2048, which is 32 full-scale steps. An input code of 127 or -128, twice full scale, therefore drives both integrators into their clamps within a few dozen samples. This makes the saturation rule and the recovery from it observable in the bit stream. The small full scale also lets a 112-sample ones count resolve the density of each test level to a few counts. Strobe gaps with a changed input check that disabled cycles leave the loop unchanged.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

    // Which bound an integrator hit on its last update
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;

    localparam int unsigned DSM2_IN_W_DEF  = 16;
    localparam int unsigned DSM2_GUARD_DEF = 6;

    function automatic int unsigned dsm2_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsm2_integ.sv
module dsm2_integ
    import dsm2_pkg::*;
#(
    parameter int unsigned ACC_W   = 22,
    parameter int unsigned DELTA_W = 18
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      en_i,
    input  logic signed [DELTA_W-1:0] delta_i,
    output logic signed [ACC_W-1:0]   acc_q_o,
    output logic                      neg_d_o
);

    localparam int unsigned SUM_W = dsm2_max(ACC_W, DELTA_W) + 1;
    localparam logic signed [SUM_W-1:0] HI_S =
        {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LO_S =
        {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        clamp_e           clamp;
    } integ_state_t;

    integ_state_t st_d, st_q;

    logic signed [SUM_W-1:0] acc_x;
    logic signed [SUM_W-1:0] dl_x;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        acc_x = SUM_W'($signed(st_q.acc));
        dl_x  = SUM_W'(delta_i);
        sum   = acc_x + dl_x;
        st_d  = st_q;
        if (en_i) begin
            if (sum > HI_S) begin
                st_d.acc   = HI_S[ACC_W-1:0];
                st_d.clamp = CLAMP_HIGH;
            end else if (sum < LO_S) begin
                st_d.acc   = LO_S[ACC_W-1:0];
                st_d.clamp = CLAMP_LOW;
            end else begin
                st_d.acc   = sum[ACC_W-1:0];
                st_d.clamp = CLAMP_NONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q_o = $signed(st_q.acc);
    assign neg_d_o = st_d.acc[ACC_W-1];

    // R6
    no_wrap_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && delta_i >= 0) |=> (acc_q_o >= $past(acc_q_o)));

    // R6
    no_wrap_dn_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && delta_i <= 0) |=> (acc_q_o <= $past(acc_q_o)));

    // R6
    clamp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.clamp == CLAMP_HIGH && en_i && delta_i >= 0) |=>
        (acc_q_o == $past(acc_q_o)));

    // R2
    integ_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(acc_q_o));

endmodule

// File: rtl/dsm2_quant.sv
module dsm2_quant #(
    parameter int unsigned IN_W       = 16,
    parameter int unsigned ACC_W      = 22,
    parameter int unsigned FULL_SCALE = 32768
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic                    neg_d_i,
    output logic                    bit_q_o,
    output logic signed [IN_W+1:0]  fb1_o,
    output logic signed [ACC_W+1:0] fb2_o
);

    localparam int unsigned FB1_W = IN_W + 2;
    localparam int unsigned FB2_W = ACC_W + 2;
    localparam logic signed [FB1_W-1:0] FS1 = FB1_W'(FULL_SCALE);
    localparam logic signed [FB2_W-1:0] FS2 = FB2_W'(2 * FULL_SCALE);

    typedef struct packed {
        logic bit_v;
    } quant_state_t;

    quant_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.bit_v = !neg_d_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_q_o = st_q.bit_v;
    assign fb1_o   = st_q.bit_v ? FS1 : -FS1;
    assign fb2_o   = st_q.bit_v ? FS2 : -FS2;

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
    import dsm2_pkg::*;
#(
    parameter int unsigned IN_W       = DSM2_IN_W_DEF,
    parameter int unsigned GUARD      = DSM2_GUARD_DEF,
    parameter int unsigned FULL_SCALE = 2 ** (DSM2_IN_W_DEF - 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   smp_en_i,
    input  logic signed [IN_W-1:0] smp_i,
    output logic                   bit_o
);

    localparam int unsigned ACC_W = IN_W + GUARD;
    localparam int unsigned D1_W  = IN_W + 2;
    localparam int unsigned D2_W  = ACC_W + 2;

    logic signed [D1_W-1:0]  fb1;
    logic signed [D2_W-1:0]  fb2;
    logic signed [D1_W-1:0]  d1;
    logic signed [D2_W-1:0]  d2;
    logic signed [ACC_W-1:0] i1_q;
    logic signed [ACC_W-1:0] i2_q;
    logic                    i1_neg_d;
    logic                    i2_neg_d;
    logic                    bit_q;

    // Input minus feedback into the first stage, first-stage state minus
    // doubled feedback into the second stage
    assign d1 = D1_W'(smp_i) - fb1;
    assign d2 = D2_W'(i1_q) - fb2;

    dsm2_integ #(
        .ACC_W   (ACC_W),
        .DELTA_W (D1_W)
    ) u_integ1 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (smp_en_i),
        .delta_i (d1),
        .acc_q_o (i1_q),
        .neg_d_o (i1_neg_d)
    );

    dsm2_integ #(
        .ACC_W   (ACC_W),
        .DELTA_W (D2_W)
    ) u_integ2 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (smp_en_i),
        .delta_i (d2),
        .acc_q_o (i2_q),
        .neg_d_o (i2_neg_d)
    );

    dsm2_quant #(
        .IN_W       (IN_W),
        .ACC_W      (ACC_W),
        .FULL_SCALE (FULL_SCALE)
    ) u_quant (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (smp_en_i),
        .neg_d_i (i2_neg_d),
        .bit_q_o (bit_q),
        .fb1_o   (fb1),
        .fb2_o   (fb2)
    );

    assign bit_o = bit_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!bit_o && i1_q == '0 && i2_q == '0));

    // R3
    quant_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_en_i |=> (bit_o == (i2_q >= 0)));

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_en_i |=> ($stable(bit_o) && $stable(i1_q) && $stable(i2_q)));

    // R6
    no_fold_neg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_en_i && d1 >= 0 && i1_q >= 0) |-> !i1_neg_d);

endmodule

// File: tb/test_dsm2_modulator.sv
`timescale 1ns/1ps
module test_dsm2_modulator;

    localparam int IN_W  = 8;
    localparam int GUARD = 4;
    localparam int FS    = 64;
    localparam int ACC_W = IN_W + GUARD;
    localparam int HI    = 2 ** (ACC_W - 1) - 1;
    localparam int LO    = -(2 ** (ACC_W - 1));
    localparam int NSMP  = 128;
    localparam int SETTLE = 16;
    localparam int TOL   = 5;

    localparam int NV = 12;
    localparam int VX    [NV] = '{0, 32, -32, 16, -48, 40, -8, -40, 127, 0, -128, 0};
    localparam bit VGAP  [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0};
    localparam bit VDENS [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic signed [IN_W-1:0] x = '0;
    logic bo;

    int checks = 0;
    int fails = 0;
    int m1 = 0;
    int m2 = 0;
    bit mb = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsm2_modulator #(
        .IN_W       (IN_W),
        .GUARD      (GUARD),
        .FULL_SCALE (FS)
    ) i_dsm2_modulator (
        .clk_i    (clk),
        .rst_i    (rst),
        .smp_en_i (en),
        .smp_i    (x),
        .bit_o    (bo)
    );

    function automatic int clampv(input int v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    // Reference loop from R3 R4 R5 R6
    task automatic model_step(input int xv);
        int fb = mb ? FS : -FS;
        int n1 = clampv(m1 + xv - fb);
        int n2 = clampv(m2 + m1 - 2 * fb);
        m1 = n1;
        m2 = n2;
        mb = (n2 >= 0);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle(input bit e, input int xv);
        @(negedge clk);
        en = e;
        x = xv[IN_W-1:0];
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit e_during);
        @(negedge clk);
        rst = 1'b1;
        en = e_during;
        x = 8'sd100;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        en = 1'b0;
        m1 = 0;
        m2 = 0;
        mb = 1'b0;
    endtask

    task automatic run_vector(input int xv, input bit gap, input bit dens);
        int mism = 0;
        int bad_act = 0;
        int bad_exp = 0;
        int ones = 0;
        int held_bad = 0;
        for (int n = 0; n < NSMP; n++) begin
            cycle(1'b1, xv);
            model_step(xv);
            if (bo !== mb) begin
                if (mism == 0) begin
                    bad_act = int'(bo);
                    bad_exp = int'(mb);
                end
                mism++;
            end
            if (n >= SETTLE && bo === 1'b1) ones++;
            if (gap) begin
                automatic logic prev = bo;
                cycle(1'b0, -xv - 5);
                if (bo !== prev) held_bad++;
            end
        end
        check(mism == 0, $sformatf("R3 R4 R5 R6 bit sequence x=%0d mismatches=%0d", xv, mism),
              bad_act, bad_exp);
        if (gap) begin
            check(held_bad == 0, $sformatf("R2 strobe low hold x=%0d", xv), held_bad, 0);
        end
        if (dens) begin
            automatic int expd = (xv + FS) * (NSMP - SETTLE) / (2 * FS);
            check(ones >= expd - TOL && ones <= expd + TOL,
                  $sformatf("R7 ones density x=%0d", xv), ones, expd);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: output low out of reset
        repeat (4) @(posedge clk);
        #1;
        check(bo === 1'b0, "R1 output after reset", int'(bo), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: strobe low with a nonzero input leaves the output at zero
        for (int k = 0; k < 5; k++) cycle(1'b0, 100);
        check(bo === 1'b0, "R2 idle after reset", int'(bo), 0);

        // R3 R5: first sample from cleared state, second stage sees 2*FS
        cycle(1'b1, 0);
        model_step(0);
        check(bo === 1'b1, "R3 R5 first sample from zero state", int'(bo), 1);

        do_reset(1'b0);

        // R4 R8: walk the stimulus table
        for (int v = 0; v < NV; v++) begin
            run_vector(VX[v], VGAP[v], VDENS[v]);
        end

        // R1: reset with the strobe high wins and clears the integrators
        do_reset(1'b1);
        #3;
        check(bo === 1'b0, "R1 reset priority over strobe", int'(bo), 0);
        run_vector(-20, 1'b0, 1'b1);

        // R1 R6: reset straight out of saturation, then restart cleanly
        run_vector(127, 1'b0, 1'b0);
        do_reset(1'b0);
        #3;
        check(bo === 1'b0, "R1 reset from saturated state", int'(bo), 0);
        run_vector(24, 1'b1, 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule